// File: doc/BRIEF.md
# Write-combining buffer

This block sits between a core's store path and memory for regions marked write-combining. Those regions are never cached, and no coherence protocol covers them. The buffer holds one memory line. It merges byte-masked word writes into that line and sends the merged line to memory as a single line write, so many small stores cost one transaction. A line write carries a per-byte valid mask, and only the bytes that were written count in it. Bytes inside the line are not ordered relative to each other.

A partly filled line stays in the buffer with no time limit. The buffer drains in these cases:
- a serializing event arrives (fence, uncached access, interrupt or locked operation);
- every byte of the line becomes valid;
- a write targets another line;
- a read targets the line that is pending.

Reads to other addresses are not held up. A read that hits the pending line waits until the line has reached memory. When a drain finishes, the buffer clears and pulses a done flag.

Top module: `write_combine_buf`

## Requirements
- R1: After reset no line write is offered, `wr_ready` and `rd_ready` are high and `drain_done` is low.
- R2: Writes to the pending line are merged and held without any line write while the line is partly filled. A later write to a byte replaces the earlier value of that byte.
- R3: The cycle after a write that makes all 32 byte-valid bits set is accepted, `lw_valid` is high, with no event needed.
- R4: If any one of `ev_fence`, `ev_uncached`, `ev_intr` or `ev_locked` is high at a clock edge while a partial line is pending, `lw_valid` is high after that edge.
- R5: While any event input is high, `wr_ready` is low. An event that arrives while the buffer is empty produces no line write and no `drain_done`.
- R6: A write to a line other than the pending one is stalled (`wr_ready` low). The pending line drains first. The write is then accepted and starts a new line.
- R7: `lw_addr` is the line base address (low 5 bits zero). `lw_mask` bit i is set exactly when byte i of the line was written. Bytes of `lw_data` whose mask bit is clear are zero.
- R8: While `lw_valid` is high and `lw_ready` is low, `lw_valid`, `lw_addr`, `lw_mask` and `lw_data` hold their values.
- R9: `drain_done` is high for exactly the one cycle after the `lw_valid`/`lw_ready` handshake, and the buffer is empty in that cycle.
- R10: A read whose line matches the pending line sees `rd_ready` low and forces a drain. `rd_ready` rises once the drain completes. A read to any other line sees `rd_ready` high and causes no drain.
- R11: A write places byte j of `wr_data` at line byte 4*`wr_addr[4:2]`+j, and only where `wr_be[j]` is set. `lw_data` byte i occupies bits 8i+7..8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted this edge when high with wr_valid |
| wr_addr | input | 32 | Byte address of the write word |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write word |
| rd_valid | input | 1 | Read request to combining memory |
| rd_addr | input | 32 | Read byte address |
| rd_ready | output | 1 | Read may proceed |
| ev_fence | input | 1 | Fence event |
| ev_uncached | input | 1 | Uncached access event |
| ev_intr | input | 1 | Interrupt event |
| ev_locked | input | 1 | Locked operation event |
| lw_valid | output | 1 | Line write offered to memory |
| lw_ready | input | 1 | Memory takes the line write |
| lw_addr | output | 32 | Line base address |
| lw_data | output | 256 | Line data, byte i at bits 8i+7..8i |
| lw_mask | output | 32 | Per-byte valid mask |
| drain_done | output | 1 | One-cycle pulse after a drain completes |

## Verification
The cycle in which each result appears is fixed:
- `wr_ready` and `rd_ready` are combinational and valid in the same cycle as the request or event.
- `lw_valid` rises one edge after the write, event or conflicting access that triggers the drain.
- `drain_done` follows the handshake edge by one cycle.

The bench drives inputs on the falling edge and samples one time unit later. So every check reads the state left by exactly the rising edges counted for that result. The stall cases are checked at the edge each one depends on: a conflicting write or a hitting read is shown blocked before the drain, and shown released in the `drain_done` cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
   typedef enum logic [1:0] {
      WCB_EMPTY = 2'd0,
      WCB_HOLD  = 2'd1,
      WCB_DRAIN = 2'd2
   } wcb_state_e;
endpackage

// File: rtl/wcb_line_store.sv
module wcb_line_store #(
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 32,
   localparam int LANE_B    = DATA_W / 8,
   localparam int LANES     = LINE_BYTES / LANE_B,
   localparam int IDX_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [LANE_B-1:0]       wr_be,
   input  logic                    clr,
   output logic [LINE_BYTES*8-1:0] line_data,
   output logic [LINE_BYTES-1:0]   line_mask,
   output logic                    merged_full
);
   logic [LINE_BYTES-1:0]   place;
   logic [LINE_BYTES*8-1:0] wide_data;
   logic [LINE_BYTES*8-1:0] data_q;
   logic [LINE_BYTES-1:0]   mask_q;

   assign wide_data = {LANES{wr_data}};

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign place[g*LANE_B +: LANE_B] =
         (wr_en && (wr_idx == IDX_W'(g))) ? wr_be : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         mask_q <= '0;
      end else if (clr) begin
         data_q <= '0;
         mask_q <= '0;
      end else begin
         for (int i = 0; i < LINE_BYTES; i++) begin
            if (place[i]) begin
               data_q[i*8 +: 8] <= wide_data[i*8 +: 8];
               mask_q[i]        <= 1'b1;
            end
         end
      end
   end

   assign line_data   = data_q;
   assign line_mask   = mask_q;
   assign merged_full = &(mask_q | place);
endmodule

// File: rtl/wcb_trigger.sv
module wcb_trigger #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5,
   localparam int TAG_W = ADDR_W - OFF_W
) (
   input  logic [TAG_W-1:0]  tag,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              ev_fence,
   input  logic              ev_uncached,
   input  logic              ev_intr,
   input  logic              ev_locked,
   output logic              wr_hit,
   output logic              rd_hit,
   output logic              ev_any
);
   assign wr_hit = (wr_addr[ADDR_W-1:OFF_W] == tag);
   assign rd_hit = (rd_addr[ADDR_W-1:OFF_W] == tag);
   assign ev_any = ev_fence | ev_uncached | ev_intr | ev_locked;
endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl #(
   parameter int TAG_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic [TAG_W-1:0] wr_line,
   input  logic             wr_hit,
   input  logic             rd_valid,
   input  logic             rd_hit,
   input  logic             ev_any,
   input  logic             merged_full,
   input  logic             lw_ready,
   output logic             wr_ready,
   output logic             rd_ready,
   output logic             store_wr,
   output logic             store_clr,
   output logic             lw_valid,
   output logic [TAG_W-1:0] tag,
   output logic             drain_done
);
   import wcb_pkg::*;

   wcb_state_e       st_q, st_d;
   logic [TAG_W-1:0] tag_q;
   logic             done_q;
   logic             wr_fire;

   always_comb begin
      wr_ready = !ev_any && ((st_q == WCB_EMPTY) || ((st_q == WCB_HOLD) && wr_hit));
      wr_fire  = wr_valid && wr_ready;
      rd_ready = (st_q == WCB_EMPTY) || !rd_hit;
      st_d     = st_q;
      case (st_q)
         WCB_EMPTY: if (wr_fire) st_d = merged_full ? WCB_DRAIN : WCB_HOLD;
         WCB_HOLD: begin
            if ((wr_fire && merged_full) || ev_any ||
                (wr_valid && !wr_hit) || (rd_valid && rd_hit))
               st_d = WCB_DRAIN;
         end
         WCB_DRAIN: if (lw_ready) st_d = WCB_EMPTY;
         default:   st_d = WCB_EMPTY;
      endcase
   end

   assign store_wr  = wr_fire;
   assign lw_valid  = (st_q == WCB_DRAIN);
   assign store_clr = lw_valid && lw_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= WCB_EMPTY;
         tag_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= store_clr;
         if ((st_q == WCB_EMPTY) && wr_fire) tag_q <= wr_line;
      end
   end

   assign tag        = tag_q;
   assign drain_done = done_q;
endmodule

// File: rtl/write_combine_buf.sv
module write_combine_buf #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 32,
   localparam int LANE_B    = DATA_W / 8,
   localparam int LANES     = LINE_BYTES / LANE_B,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LOFF_W    = (LANE_B > 1) ? $clog2(LANE_B) : 0,
   localparam int IDX_W     = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int TAG_W     = ADDR_W - OFF_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_valid,
   output logic                    wr_ready,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [LANE_B-1:0]       wr_be,
   input  logic                    rd_valid,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic                    rd_ready,
   input  logic                    ev_fence,
   input  logic                    ev_uncached,
   input  logic                    ev_intr,
   input  logic                    ev_locked,
   output logic                    lw_valid,
   input  logic                    lw_ready,
   output logic [ADDR_W-1:0]       lw_addr,
   output logic [LINE_BYTES*8-1:0] lw_data,
   output logic [LINE_BYTES-1:0]   lw_mask,
   output logic                    drain_done
);
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 2 * LANE_B) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding at least two words");
   end
   if ((LANE_B & (LANE_B - 1)) != 0) begin : g_bad_lane
      $error("DATA_W/8 must be a power of two");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W too small for the line size");
   end

   logic             wr_hit, rd_hit, ev_any, merged_full;
   logic             store_wr, store_clr;
   logic [TAG_W-1:0] tag;
   logic [IDX_W-1:0] wr_idx;

   if (LANES > 1) begin : g_idx
      assign wr_idx = wr_addr[OFF_W-1:LOFF_W];
   end else begin : g_idx_one
      assign wr_idx = '0;
   end

   wcb_trigger #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_trigger (
      .tag(tag), .wr_addr(wr_addr), .rd_addr(rd_addr),
      .ev_fence(ev_fence), .ev_uncached(ev_uncached),
      .ev_intr(ev_intr), .ev_locked(ev_locked),
      .wr_hit(wr_hit), .rd_hit(rd_hit), .ev_any(ev_any)
   );

   wcb_ctrl #(.TAG_W(TAG_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_line(wr_addr[ADDR_W-1:OFF_W]), .wr_hit(wr_hit),
      .rd_valid(rd_valid), .rd_hit(rd_hit), .ev_any(ev_any),
      .merged_full(merged_full), .lw_ready(lw_ready),
      .wr_ready(wr_ready), .rd_ready(rd_ready),
      .store_wr(store_wr), .store_clr(store_clr),
      .lw_valid(lw_valid), .tag(tag), .drain_done(drain_done)
   );

   wcb_line_store #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(store_wr), .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be),
      .clr(store_clr),
      .line_data(lw_data), .line_mask(lw_mask), .merged_full(merged_full)
   );

   assign lw_addr = {tag, {OFF_W{1'b0}}};

   // R7
   lw_mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lw_valid |-> (lw_mask != '0));

   // R8
   lw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lw_valid && !lw_ready) |=> (lw_valid && $stable(lw_mask) &&
                                   $stable(lw_data) && $stable(lw_addr)));

   // R9
   drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lw_valid && lw_ready) |=> (drain_done && (lw_mask == '0) && !lw_valid));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |=> !drain_done);

   // R10
   rd_hit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready && (lw_mask != '0)) |->
         (rd_addr[ADDR_W-1:OFF_W] != lw_addr[ADDR_W-1:OFF_W]));
endmodule

// File: tb/test_write_combine_buf.sv
module test_write_combine_buf;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_valid, wr_ready;
   logic [31:0]  wr_addr, wr_data;
   logic [3:0]   wr_be;
   logic         rd_valid, rd_ready;
   logic [31:0]  rd_addr;
   logic         ev_fence, ev_uncached, ev_intr, ev_locked;
   logic         lw_valid, lw_ready;
   logic [31:0]  lw_addr;
   logic [255:0] lw_data;
   logic [31:0]  lw_mask;
   logic         drain_done;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   write_combine_buf i_write_combine_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .ev_fence(ev_fence), .ev_uncached(ev_uncached),
      .ev_intr(ev_intr), .ev_locked(ev_locked),
      .lw_valid(lw_valid), .lw_ready(lw_ready), .lw_addr(lw_addr),
      .lw_data(lw_data), .lw_mask(lw_mask), .drain_done(drain_done)
   );

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      @(negedge clk);
      wr_valid = 1'b0;
      #1;
   endtask

   task automatic set_ev(input int k, input logic v);
      case (k)
         0: ev_fence    = v;
         1: ev_uncached = v;
         2: ev_intr     = v;
         default: ev_locked = v;
      endcase
   endtask

   // one-cycle event pulse; write stall checked while it is high
   task automatic pulse_event(input int k);
      @(negedge clk);
      set_ev(k, 1'b1);
      #1;
      chk("R5 wr_ready low during event", 256'(wr_ready), 256'd0);
      @(negedge clk);
      set_ev(k, 1'b0);
      #1;
   endtask

   task automatic finish_drain();
      lw_ready = 1'b1;
      @(negedge clk); #1;
      chk("R9 drain_done after handshake", 256'(drain_done), 256'd1);
      chk("R9 lw_valid cleared", 256'(lw_valid), 256'd0);
      lw_ready = 1'b0;
      @(negedge clk); #1;
      chk("R9 drain_done single cycle", 256'(drain_done), 256'd0);
   endtask

   task automatic t_reset();
      chk("R1 lw_valid at reset", 256'(lw_valid), 256'd0);
      chk("R1 wr_ready at reset", 256'(wr_ready), 256'd1);
      chk("R1 rd_ready at reset", 256'(rd_ready), 256'd1);
      chk("R1 drain_done at reset", 256'(drain_done), 256'd0);
   endtask

   task automatic t_merge();
      logic [255:0] exp;
      put(32'h100, 32'h11223344, 4'hF);
      put(32'h100, 32'h0000AA00, 4'h2);
      put(32'h114, 32'h99000000, 4'h8);
      repeat (3) @(negedge clk);
      #1;
      chk("R2 partial line held", 256'(lw_valid), 256'd0);
      pulse_event(0);
      chk("R4 fence drains", 256'(lw_valid), 256'd1);
      chk("R7 line address", 256'(lw_addr), 256'h100);
      chk("R11 byte mask", 256'(lw_mask), 256'h0080000F);
      exp = '0;
      exp[31:0]    = 32'h1122AA44;
      exp[191:160] = 32'h99000000;
      chk("R2 R7 merged data", lw_data, exp);
      repeat (2) @(negedge clk);
      #1;
      chk("R8 lw_valid held", 256'(lw_valid), 256'd1);
      chk("R8 mask held", 256'(lw_mask), 256'h0080000F);
      chk("R8 data held", lw_data, exp);
      finish_drain();
   endtask

   task automatic t_events();
      for (int k = 0; k < 4; k++) begin
         put(32'h700, 32'hCAFE0000 + k, 4'hC);
         pulse_event(k);
         chk($sformatf("R4 event %0d drains", k), 256'(lw_valid), 256'd1);
         chk($sformatf("R4 event %0d mask", k), 256'(lw_mask), 256'hC);
         finish_drain();
      end
   endtask

   task automatic t_empty_event();
      for (int k = 0; k < 4; k++) begin
         pulse_event(k);
         chk($sformatf("R5 empty event %0d no line", k), 256'(lw_valid), 256'd0);
         @(negedge clk); #1;
         chk($sformatf("R5 empty event %0d no done", k), 256'(drain_done), 256'd0);
      end
   endtask

   task automatic t_full();
      logic [255:0] exp;
      exp = '0;
      for (int i = 0; i < 8; i++) begin
         put(32'h200 + 4 * i, 32'h01010101 * (i + 1), 4'hF);
         exp[i*32 +: 32] = 32'h01010101 * (i + 1);
         if (i == 6) chk("R3 seven words still held", 256'(lw_valid), 256'd0);
      end
      chk("R3 full line drains", 256'(lw_valid), 256'd1);
      chk("R3 full mask", 256'(lw_mask), 256'hFFFFFFFF);
      chk("R11 full data", lw_data, exp);
      chk("R7 full address", 256'(lw_addr), 256'h200);
      finish_drain();
   endtask

   task automatic t_newline();
      put(32'h308, 32'h000000AB, 4'h1);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 32'h400; wr_data = 32'h5555AAAA; wr_be = 4'hF;
      #1;
      chk("R6 other line stalled", 256'(wr_ready), 256'd0);
      @(negedge clk); #1;
      chk("R6 old line drains", 256'(lw_valid), 256'd1);
      chk("R6 old line address", 256'(lw_addr), 256'h300);
      chk("R6 old line mask", 256'(lw_mask), 256'h100);
      chk("R7 old line data", lw_data, 256'hAB << 64);
      lw_ready = 1'b1;
      @(negedge clk); #1;
      chk("R6 drain_done", 256'(drain_done), 256'd1);
      chk("R6 new write released", 256'(wr_ready), 256'd1);
      lw_ready = 1'b0;
      @(negedge clk);
      wr_valid = 1'b0;
      #1;
      pulse_event(2);
      chk("R6 new line address", 256'(lw_addr), 256'h400);
      chk("R6 new line mask", 256'(lw_mask), 256'hF);
      chk("R6 new line data", lw_data, 256'h5555AAAA);
      finish_drain();
   endtask

   task automatic t_read();
      put(32'h500, 32'h00000001, 4'hF);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = 32'h600;
      #1;
      chk("R10 read miss proceeds", 256'(rd_ready), 256'd1);
      @(negedge clk); #1;
      chk("R10 read miss no drain", 256'(lw_valid), 256'd0);
      rd_addr = 32'h51C;
      #1;
      chk("R10 read hit blocked", 256'(rd_ready), 256'd0);
      @(negedge clk); #1;
      chk("R10 read hit drains", 256'(lw_valid), 256'd1);
      chk("R10 read still blocked", 256'(rd_ready), 256'd0);
      lw_ready = 1'b1;
      @(negedge clk); #1;
      chk("R10 read released", 256'(rd_ready), 256'd1);
      chk("R9 done after read drain", 256'(drain_done), 256'd1);
      lw_ready = 1'b0;
      rd_valid = 1'b0;
      @(negedge clk); #1;
   endtask

   initial begin
      rst_n = 1'b0;
      wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
      rd_valid = 1'b0; rd_addr = '0;
      ev_fence = 1'b0; ev_uncached = 1'b0; ev_intr = 1'b0; ev_locked = 1'b0;
      lw_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_merge();
      t_events();
      t_empty_event();
      t_full();
      t_newline();
      t_read();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule